// File: doc/BRIEF.md
# Link-Clock SYSREF Source and Multiframe Phase Counter

This block sits beside a subclass 1 serial converter receiver and keeps the local multiframe clock (LMFC) phase. It runs entirely in the link clock domain, where each clock carries four octets per lane. The local multiframe therefore lasts F×K/4 link clocks, where F is the octet count of a frame and K is the frame count of a multiframe. For example, F=2 and K=32 give a 16-clock multiframe, which is 7.68 MHz at a 122.88 MHz link clock. F=2 and K=16 halve that to 8 clocks, or 15.36 MHz.

A free-running generator produces a periodic SYSREF pulse whose period is a whole number of multiframes. The same pulse can drive the converter and be looped back, or an external SYSREF can be selected instead. The chosen SYSREF is resynchronised, and its rising edge re-phases the multiframe counter. After that restart the counter's wrap point coincides with the SYSREF edge. Detection either locks on the first edge after reset or keeps re-phasing on every edge. In both modes, any edge seen after the first alignment is compared with the running counter, and a sticky flag records an edge that misses the multiframe boundary.

Top module: `sysref_lmfc_top`

## Requirements
- R1: While `rst` is high (synchronous, active high), `sysref_out`, `lmfc_tick`, `lmfc_count` and `lmfc_err` are all 0.
- R2: The local SYSREF is high for PULSE_W clocks, starting in the first cycle after reset release, and repeats with a period of MF_PER_SYSREF × F×K/4 clocks.
- R3: `lmfc_count` steps by one each clock from 0 up to F×K/4−1 and then wraps to 0. F×K must be a multiple of 4.
- R4: After the first clock following reset, `lmfc_tick` is high in exactly those cycles in which `lmfc_count` is 0.
- R5: With `sysref_sel_ext`=1 only `sysref_ext` is observed. With `sysref_sel_ext`=0 only the local SYSREF is observed.
- R6: Suppose the selected SYSREF is first sampled high at clock edge t after being low at edge t−1. If that edge restarts the counter, `lmfc_count` reads 0 after edge t+SYNC_STAGES. A level held high for several clocks counts as one edge.
- R7: With `det_every`=0, only the first captured edge after reset restarts the counter. Later edges leave the count sequence untouched.
- R8: With `det_every`=1, every captured edge restarts the counter.
- R9: In either mode, a captured edge arriving after the first alignment while `lmfc_count` is not F×K/4−1 sets `lmfc_err` at the restart edge. Only reset clears it. An edge that lands exactly on the boundary leaves it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_frame_octets | input | F_W | Octets per frame (F), static outside reset |
| cfg_frames_per_mf | input | K_W | Frames per multiframe (K), static outside reset |
| det_every | input | 1 | 0: align on first SYSREF edge only; 1: align on every edge |
| sysref_sel_ext | input | 1 | 0: loop local SYSREF back; 1: use `sysref_ext` |
| sysref_ext | input | 1 | External SYSREF level |
| sysref_out | output | 1 | Locally generated periodic SYSREF |
| lmfc_tick | output | 1 | One-clock strobe at each multiframe start |
| lmfc_count | output | F_W+K_W−2 | Multiframe phase counter |
| lmfc_err | output | 1 | Sticky flag for a SYSREF edge off the multiframe boundary |

## Verification
The hardest condition to reach is a SYSREF edge that lands off the boundary after alignment. The looped-back source can never produce it, because its period is a whole number of multiframes. The stimulus therefore switches to the external input and places pulses at hand-picked clocks. The first pulse aligns the counter. A second pulse is timed so that its restart falls mid-multiframe, once in first-only mode (the count must carry on) and once in every-edge mode (the count must jump to 0). An external level held high for three clocks checks that a long pulse yields a single restart.

// File: rtl/sysref_lmfc_pkg.sv
`timescale 1ns/1ps
package sysref_lmfc_pkg;

    typedef enum logic {
        DET_FIRST_ONLY = 1'b0,
        DET_EVERY_EDGE = 1'b1
    } det_mode_e;

    typedef enum logic {
        SRC_LOCAL    = 1'b0,
        SRC_EXTERNAL = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic aligned;
        logic err;
    } align_state_t;

    // Bits needed for the SYSREF period counter.
    function automatic int period_width(int cnt_w, int mult, int pulse_w);
        int w;
        w = cnt_w + $clog2(mult + 1);
        if (w < $clog2(pulse_w + 1) + 1) w = $clog2(pulse_w + 1) + 1;
        return w;
    endfunction

endpackage

// File: rtl/sysref_pulse_gen.sv
`timescale 1ns/1ps
module sysref_pulse_gen
    import sysref_lmfc_pkg::*;
#(
    parameter int CNT_W         = 9,
    parameter int PULSE_W       = 2,
    parameter int MF_PER_SYSREF = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] mf_len,
    output logic             pulse_o
);
    localparam int PER_W = period_width(CNT_W, MF_PER_SYSREF, PULSE_W);
    localparam logic [PER_W-1:0] MULT_L = PER_W'(MF_PER_SYSREF);
    localparam logic [PER_W-1:0] PW_L   = PER_W'(PULSE_W);
    localparam logic [PER_W-1:0] ONE_L  = PER_W'(1);

    logic [PER_W-1:0] period;
    logic [PER_W-1:0] last_phase;
    logic [PER_W-1:0] phase_q;
    logic             pulse_q;

    assign period     = PER_W'(mf_len) * MULT_L;
    assign last_phase = period - ONE_L;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= (phase_q < PW_L);
            phase_q <= (phase_q >= last_phase) ? '0 : phase_q + ONE_L;
        end
    end

    assign pulse_o = pulse_q;

    AST_PERIOD_ABOVE_PULSE: assert property (@(posedge clk) disable iff (rst) period > PW_L); // R2
    AST_PULSE_HELD: assert property (@(posedge clk) disable iff (rst) (PULSE_W > 1) && $rose(pulse_q) |=> pulse_q); // R2

endmodule

// File: rtl/sysref_edge_capture.sv
`timescale 1ns/1ps
module sysref_edge_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic cap_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    if (SYNC_STAGES == 1) begin : g_single
        always_ff @(posedge clk) begin
            if (rst) sync_q <= '0;
            else     sync_q <= din;
        end
    end else begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) sync_q <= '0;
            else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign cap_o = sync_q[SYNC_STAGES-1] & ~prev_q;

    AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (rst) cap_o |=> !cap_o); // R6

endmodule

// File: rtl/lmfc_phase_counter.sv
`timescale 1ns/1ps
module lmfc_phase_counter
    import sysref_lmfc_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] mf_len,
    input  det_mode_e        mode,
    input  logic             cap_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tick_o,
    output logic             err_o
);
    localparam logic [CNT_W-1:0] ONE_L = CNT_W'(1);

    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_wrap;
    logic [CNT_W-1:0] cnt_nxt;
    align_state_t     st_q;
    align_state_t     st_nxt;
    logic             restart;
    logic             off_bnd;
    logic             tick_q;

    always_comb begin
        last_idx = mf_len - ONE_L;
        cnt_wrap = (cnt_q >= last_idx) ? '0 : cnt_q + ONE_L;
        restart  = cap_i && (!st_q.aligned || (mode == DET_EVERY_EDGE));
        off_bnd  = cap_i && st_q.aligned && (cnt_q != last_idx);
        cnt_nxt  = restart ? '0 : cnt_wrap;
        st_nxt   = st_q;
        if (cap_i)   st_nxt.aligned = 1'b1;
        if (off_bnd) st_nxt.err     = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            st_q   <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt;
            st_q   <= st_nxt;
            tick_q <= (cnt_nxt == '0);
        end
    end

    assign cnt_o  = cnt_q;
    assign tick_o = tick_q;
    assign err_o  = st_q.err;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) cnt_q <= last_idx); // R3
    AST_TICK_AT_ZERO: assert property (@(posedge clk) disable iff (rst) tick_q |-> (cnt_q == '0)); // R4
    AST_FIRST_ONLY_HOLD: assert property (@(posedge clk) disable iff (rst) cap_i && st_q.aligned && (mode == DET_FIRST_ONLY) && (cnt_q < last_idx) |=> cnt_q != '0); // R7
    AST_EVERY_RESTART: assert property (@(posedge clk) disable iff (rst) cap_i && (mode == DET_EVERY_EDGE) |=> cnt_q == '0); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) st_q.err |=> st_q.err); // R9

endmodule

// File: rtl/sysref_lmfc_top.sv
`timescale 1ns/1ps
module sysref_lmfc_top
    import sysref_lmfc_pkg::*;
#(
    parameter int F_W           = 5,
    parameter int K_W           = 6,
    parameter int PULSE_W       = 2,
    parameter int MF_PER_SYSREF = 1,
    parameter int SYNC_STAGES   = 2,
    localparam int CNT_W        = F_W + K_W - 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [F_W-1:0]   cfg_frame_octets,
    input  logic [K_W-1:0]   cfg_frames_per_mf,
    input  logic             det_every,
    input  logic             sysref_sel_ext,
    input  logic             sysref_ext,
    output logic             sysref_out,
    output logic             lmfc_tick,
    output logic [CNT_W-1:0] lmfc_count,
    output logic             lmfc_err
);
    localparam int PROD_W = F_W + K_W;

    logic [PROD_W-1:0] fk_prod;
    logic [CNT_W-1:0]  mf_len;
    src_sel_e          src_sel;
    det_mode_e         mode;
    logic              sref_pick;
    logic              cap;

    assign fk_prod   = PROD_W'(cfg_frame_octets) * PROD_W'(cfg_frames_per_mf);
    assign mf_len    = fk_prod[PROD_W-1:2];
    assign src_sel   = src_sel_e'(sysref_sel_ext);
    assign mode      = det_mode_e'(det_every);
    assign sref_pick = (src_sel == SRC_EXTERNAL) ? sysref_ext : sysref_out;

    sysref_pulse_gen #(
        .CNT_W         (CNT_W),
        .PULSE_W       (PULSE_W),
        .MF_PER_SYSREF (MF_PER_SYSREF)
    ) u_gen (
        .clk     (clk),
        .rst     (rst),
        .mf_len  (mf_len),
        .pulse_o (sysref_out)
    );

    sysref_edge_capture #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cap (
        .clk   (clk),
        .rst   (rst),
        .din   (sref_pick),
        .cap_o (cap)
    );

    lmfc_phase_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .mf_len (mf_len),
        .mode   (mode),
        .cap_i  (cap),
        .cnt_o  (lmfc_count),
        .tick_o (lmfc_tick),
        .err_o  (lmfc_err)
    );

    AST_FK_MULT4: assert property (@(posedge clk) disable iff (rst) fk_prod[1:0] == 2'b00); // R3

endmodule

// File: tb/sysref_lmfc_top_test.sv
`timescale 1ns/1ps
module sysref_lmfc_top_test;
    localparam int S    = 2;
    localparam int PW   = 2;
    localparam int MFPS = 1;
    localparam int HD   = S + 2;

    typedef struct {
        bit sref;
        bit tick;
        int cnt;
        bit err;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] cfg_f = 5'd2;
    logic [5:0] cfg_k = 6'd32;
    logic       det_every = 1'b0;
    logic       sel_ext = 1'b0;
    logic       ext = 1'b0;
    logic       sysref_out, lmfc_tick, lmfc_err;
    logic [8:0] lmfc_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    sysref_lmfc_top uut (
        .clk(clk), .rst(rst),
        .cfg_frame_octets(cfg_f), .cfg_frames_per_mf(cfg_k),
        .det_every(det_every), .sysref_sel_ext(sel_ext), .sysref_ext(ext),
        .sysref_out(sysref_out), .lmfc_tick(lmfc_tick),
        .lmfc_count(lmfc_count), .lmfc_err(lmfc_err)
    );

    always #2.5 clk = ~clk;

    // Reference model state
    int  m_n = 0, m_L = 16, m_P = 16, m_cnt = 0;
    bit  m_aligned = 0, m_err = 0, m_sref = 0, m_tick = 0;
    bit  hist [HD];
    bit  rec_v = 0, rec_rst = 1, rec_every = 0;
    exp_t sb [$];

    always @(posedge clk) begin
        rec_v     = sel_ext ? ext : m_sref;
        rec_rst   = rst;
        rec_every = det_every;
    end

    always @(negedge clk) begin
        bit cap;
        exp_t e;
        if (rec_rst) begin
            m_n = 0; m_cnt = 0; m_aligned = 0; m_err = 0; m_sref = 0; m_tick = 0;
            for (int i = 0; i < HD; i++) hist[i] = 0;
            m_L = (int'(cfg_f) * int'(cfg_k)) / 4;
            m_P = m_L * MFPS;
        end else begin
            m_n++;
            m_sref = ((m_n - 1) % m_P) < PW;
            for (int i = HD - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = rec_v;
            cap = hist[S] && !hist[S+1];
            if (cap && m_aligned && (m_cnt != m_L - 1)) m_err = 1;
            if (cap && (!m_aligned || rec_every)) begin
                m_cnt = 0;
            end else begin
                m_cnt = (m_cnt == m_L - 1) ? 0 : m_cnt + 1;
            end
            if (cap) m_aligned = 1;
            m_tick = (m_cnt == 0);
        end
        e.sref = m_sref; e.tick = m_tick; e.cnt = m_cnt; e.err = m_err;
        sb.push_back(e);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Scoreboard monitor
    always begin
        exp_t e;
        @(negedge clk);
        #1;
        while (sb.size() > 0) begin
            e = sb.pop_front();
            check(sysref_out == e.sref, "R2", "sysref_out", sysref_out, e.sref);
            check(int'(lmfc_count) == e.cnt, "R3", "lmfc_count", lmfc_count, e.cnt);
            check(lmfc_tick == e.tick, "R4", "lmfc_tick", lmfc_tick, e.tick);
            check(lmfc_err == e.err, "R9", "lmfc_err", lmfc_err, e.err);
        end
    end

    task automatic wait_edge(input int k);
        forever begin
            @(negedge clk);
            #1.5;
            if (m_n >= k) break;
        end
    endtask

    task automatic link_reset(input int f, input int k, input bit use_ext, input bit every);
        @(negedge clk); #1.5;
        rst = 1'b1;
        cfg_f = 5'(f); cfg_k = 6'(k);
        sel_ext = use_ext; det_every = every; ext = 1'b0;
        repeat (3) begin @(negedge clk); #1.5; end
        check(sysref_out == 0, "R1", "reset sysref_out", sysref_out, 0);
        check(lmfc_count == 0, "R1", "reset lmfc_count", lmfc_count, 0);
        check(lmfc_tick == 0, "R1", "reset lmfc_tick", lmfc_tick, 0);
        check(lmfc_err == 0, "R1", "reset lmfc_err", lmfc_err, 0);
        rst = 1'b0;
    endtask

    initial begin
        // Phase 1: local loopback, F=2 K=32 (16 clocks), first-only mode
        link_reset(2, 32, 0, 0);
        wait_edge(2);  check(sysref_out == 1, "R2", "pulse high", sysref_out, 1);
        wait_edge(3);  check(sysref_out == 0, "R2", "pulse low", sysref_out, 0);
        wait_edge(4);  check(lmfc_count == 0, "R6", "restart count", lmfc_count, 0);
                       check(lmfc_tick == 1, "R6", "restart tick", lmfc_tick, 1);
        wait_edge(5);  check(lmfc_count == 1, "R3", "step", lmfc_count, 1);
        wait_edge(17); check(sysref_out == 1, "R2", "second pulse", sysref_out, 1);
        wait_edge(19); check(lmfc_count == 15, "R3", "top value", lmfc_count, 15);
        wait_edge(20); check(lmfc_count == 0, "R4", "wrap count", lmfc_count, 0);
                       check(lmfc_tick == 1, "R4", "wrap tick", lmfc_tick, 1);
        wait_edge(200); check(lmfc_err == 0, "R9", "on-boundary no error", lmfc_err, 0);
        det_every = 1'b1;
        wait_edge(260); check(lmfc_count == 0, "R8", "every-mode phase kept", lmfc_count, 0);
                        check(lmfc_err == 0, "R8", "every-mode no error", lmfc_err, 0);

        // Phase 2: external source, F=2 K=16 (8 clocks), first-only mode
        link_reset(2, 16, 1, 0);
        wait_edge(10); check(lmfc_count == 2, "R5", "local sysref ignored", lmfc_count, 2);
        ext = 1'b1;
        wait_edge(11); ext = 1'b0;
        wait_edge(13); check(lmfc_count == 0, "R5", "external aligns", lmfc_count, 0);
        wait_edge(20); ext = 1'b1;
        wait_edge(21); ext = 1'b0;
        wait_edge(22); check(lmfc_err == 0, "R9", "not yet flagged", lmfc_err, 0);
        wait_edge(23); check(lmfc_count == 2, "R7", "first-only count kept", lmfc_count, 2);
                       check(lmfc_err == 1, "R9", "off-boundary flagged", lmfc_err, 1);
        wait_edge(40); check(lmfc_err == 1, "R9", "flag sticky", lmfc_err, 1);

        // Phase 3: external source, F=1 K=20 (5 clocks), every-edge mode
        link_reset(1, 20, 1, 1);
        check(lmfc_err == 0, "R1", "flag cleared by reset", lmfc_err, 0);
        wait_edge(10); ext = 1'b1;
        wait_edge(13); ext = 1'b0;
                       check(lmfc_count == 0, "R8", "first restart", lmfc_count, 0);
        wait_edge(16); check(lmfc_count == 3, "R6", "long pulse single edge", lmfc_count, 3);
        wait_edge(21); ext = 1'b1;
        wait_edge(22); ext = 1'b0;
        wait_edge(24); check(lmfc_count == 0, "R8", "off-boundary restart", lmfc_count, 0);
                       check(lmfc_err == 1, "R9", "every-mode flagged", lmfc_err, 1);
        wait_edge(25); check(lmfc_count == 1, "R3", "continues after restart", lmfc_count, 1);

        // Phase 4: local loopback, F=4 K=8 (8 clocks), every-edge mode
        link_reset(4, 8, 0, 1);
        wait_edge(60); check(lmfc_count == 0, "R8", "loopback every-mode", lmfc_count, 0);
                       check(lmfc_tick == 1, "R4", "tick at boundary", lmfc_tick, 1);
                       check(lmfc_err == 0, "R9", "loopback no error", lmfc_err, 0);

        wait_edge(64);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule